// File: doc/BRIEF.md
# Scan-Accessible Reference CRC Register

This block keeps the reference checksum that a configuration-memory scrubber compares its computed checksum against. At the end of configuration the precomputed value arrives on a parallel bus and is stored with a single load pulse. From then on, a test-access data path can read and rewrite the reference one bit at a time, without halting the checker.

The path follows the usual capture, shift and update steps of a boundary-scan data register. The test-access state machine is outside this block and reports its state on three strobes. Access is granted only when the device is in user mode and the 10-bit instruction register holds the selecting code. Because the capture step copies the live reference into a shadow chain, a scan that writes a new value also shifts out the old one. A tester can therefore save the correct reference, inject a wrong one, watch the error flag rise after the next completed pass, and then put the saved value back.

The error flag is refreshed only at the end of each checking pass. A rewrite of the reference takes effect at the next pass boundary and never restarts the pass in progress.

Top module: `refcrc_scan_reg`

## Requirements
- R1: A high `cfg_load` on a clock edge stores `cfg_crc` into the reference (`ref_crc`), and this load wins over a scan update in the same cycle.
- R2: The register is selected only while `user_mode` is 1 and `ir_value` equals 10'b00_0001_0101 (0x015). `tdo_oe` is 1 only in a cycle where the register is selected and `shift_dr` is high.
- R3: A `capture_dr` cycle while selected copies the reference into the 32-bit shadow chain. Each following `shift_dr` cycle presents shadow bit 0 on `tdo` and moves `tdi` in at bit 31, so the old reference leaves least significant bit first.
- R4: An `update_dr` cycle while selected writes the shadow chain into `ref_crc`, visible after that clock edge.
- R5: While `user_mode` is 0, capture, shift and update strobes leave `ref_crc` unchanged and keep `tdo_oe` at 0, even when `ir_value` holds 0x015.
- R6: While another instruction is held (including codes differing from 0x015 in one bit), scans leave `ref_crc` unchanged and `tdo` reads 0 with `tdo_oe` at 0.
- R7: On a cycle with `pass_done` high, `crc_err` becomes 1 if `calc_crc` differs from the current `ref_crc` and 0 if they match. Between passes `crc_err` holds, including across reference rewrites.
- R8: After reset `ref_crc` is 0, `crc_err` is 0, and `tdo` and `tdo_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode | input | 1 | 1 once configuration is finished; gates scan access |
| ir_value | input | 10 | Current instruction register contents |
| capture_dr | input | 1 | Test state machine is in the capture step |
| shift_dr | input | 1 | Test state machine is in the shift step |
| update_dr | input | 1 | Test state machine is in the update step |
| tdi | input | 1 | Serial scan data in |
| tdo | output | 1 | Serial scan data out, 0 when not driven |
| tdo_oe | output | 1 | 1 while this register drives `tdo` |
| cfg_load | input | 1 | End-of-configuration parallel load strobe |
| cfg_crc | input | 32 | Precomputed checksum for the parallel load |
| pass_done | input | 1 | Checker finished a pass this cycle |
| calc_crc | input | 32 | Checksum computed by the finished pass |
| ref_crc | output | 32 | Current reference checksum |
| crc_err | output | 1 | Mismatch result of the last finished pass |

## Verification
Every cycle, the assertions check these rules:
- The output enable is gated by user mode, the instruction code and the shift strobe.
- The reference changes only on a load or a selected update, and takes the right value when it does.
- A capture copies the reference into the shadow chain.
- The error flag changes only at a pass boundary, to the comparison of that cycle.

Only the bench scenarios can show the bit order of a full scan. Those scenarios shift out the saved value while a bad one goes in, raise the flag at the next pass, and clear it after the correct value is restored. They also show that scans outside user mode or under a neighbouring instruction code leave no trace.

// File: rtl/refcrc_pkg.sv
package refcrc_pkg;
   localparam int unsigned DEF_CRC_W = 32;
   localparam int unsigned DEF_IR_W  = 10;
   localparam logic [DEF_IR_W-1:0] DEF_SEL_CODE = 10'b00_0001_0101;

   typedef enum logic [1:0] {
      DR_IDLE    = 2'd0,
      DR_CAPTURE = 2'd1,
      DR_SHIFT   = 2'd2,
      DR_UPDATE  = 2'd3
   } dr_op_e;
endpackage

// File: rtl/refcrc_ir_match.sv
module refcrc_ir_match #(
   parameter int unsigned IR_W = 10,
   parameter logic [IR_W-1:0] SEL_CODE = '0
) (
   input  logic            user_mode,
   input  logic [IR_W-1:0] ir_value,
   output logic            sel
);
   always_comb sel = user_mode && (ir_value == SEL_CODE);
endmodule

// File: rtl/refcrc_shadow_chain.sv
module refcrc_shadow_chain
   import refcrc_pkg::*;
#(
   parameter int unsigned CRC_W     = 32,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dr_op_e           op,
   input  logic             tdi,
   input  logic [CRC_W-1:0] cap_val,
   output logic [CRC_W-1:0] shadow,
   output logic             ser_out
);
   logic [CRC_W-1:0] shifted;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb shifted = {tdi, shadow[CRC_W-1:1]};
         always_comb ser_out = shadow[0];
      end else begin : g_msb
         always_comb shifted = {shadow[CRC_W-2:0], tdi};
         always_comb ser_out = shadow[CRC_W-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else begin
         case (op)
            DR_CAPTURE: shadow <= cap_val;
            DR_SHIFT:   shadow <= shifted;
            default:    shadow <= shadow;
         endcase
      end
   end
endmodule

// File: rtl/refcrc_hold_reg.sv
module refcrc_hold_reg #(
   parameter int unsigned CRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [CRC_W-1:0] cfg_crc,
   input  logic             wr_en,
   input  logic [CRC_W-1:0] wr_val,
   output logic [CRC_W-1:0] ref_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ref_q <= '0;
      else if (cfg_load) ref_q <= cfg_crc;
      else if (wr_en)    ref_q <= wr_val;
   end
endmodule

// File: rtl/refcrc_err_cmp.sv
module refcrc_err_cmp #(
   parameter int unsigned CRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pass_done,
   input  logic [CRC_W-1:0] calc_crc,
   input  logic [CRC_W-1:0] ref_val,
   output logic             err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         err <= 1'b0;
      else if (pass_done) err <= (calc_crc != ref_val);
   end
endmodule

// File: rtl/refcrc_scan_reg.sv
module refcrc_scan_reg
   import refcrc_pkg::*;
#(
   parameter int unsigned CRC_W     = DEF_CRC_W,
   parameter int unsigned IR_W      = DEF_IR_W,
   parameter logic [IR_W-1:0] SEL_CODE = DEF_SEL_CODE,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             user_mode,
   input  logic [IR_W-1:0]  ir_value,
   input  logic             capture_dr,
   input  logic             shift_dr,
   input  logic             update_dr,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_oe,
   input  logic             cfg_load,
   input  logic [CRC_W-1:0] cfg_crc,
   input  logic             pass_done,
   input  logic [CRC_W-1:0] calc_crc,
   output logic [CRC_W-1:0] ref_crc,
   output logic             crc_err
);
   generate
      if (CRC_W < 2) begin : g_bad_crc_w
         $error("refcrc_scan_reg: CRC_W must be at least 2");
      end
      if (IR_W < 2 || IR_W > 32) begin : g_bad_ir_w
         $error("refcrc_scan_reg: IR_W must lie in 2..32");
      end
   endgenerate

   logic             dr_sel;
   dr_op_e           op;
   logic [CRC_W-1:0] shadow_q;
   logic             chain_out;

   refcrc_ir_match #(.IR_W(IR_W), .SEL_CODE(SEL_CODE)) u_match (
      .user_mode (user_mode),
      .ir_value  (ir_value),
      .sel       (dr_sel)
   );

   always_comb begin
      op = DR_IDLE;
      if (dr_sel) begin
         if (capture_dr)     op = DR_CAPTURE;
         else if (shift_dr)  op = DR_SHIFT;
         else if (update_dr) op = DR_UPDATE;
      end
   end

   refcrc_shadow_chain #(.CRC_W(CRC_W), .LSB_FIRST(LSB_FIRST)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .tdi     (tdi),
      .cap_val (ref_crc),
      .shadow  (shadow_q),
      .ser_out (chain_out)
   );

   refcrc_hold_reg #(.CRC_W(CRC_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .cfg_crc  (cfg_crc),
      .wr_en    (op == DR_UPDATE),
      .wr_val   (shadow_q),
      .ref_q    (ref_crc)
   );

   refcrc_err_cmp #(.CRC_W(CRC_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .pass_done (pass_done),
      .calc_crc  (calc_crc),
      .ref_val   (ref_crc),
      .err       (crc_err)
   );

   always_comb begin
      tdo_oe = (op == DR_SHIFT);
      tdo    = tdo_oe ? chain_out : 1'b0;
   end
endmodule

// File: rtl/refcrc_scan_chk.sv
module refcrc_scan_chk #(
   parameter int unsigned CRC_W = 32,
   parameter int unsigned IR_W  = 10,
   parameter logic [IR_W-1:0] SEL_CODE = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             user_mode,
   input logic [IR_W-1:0]  ir_value,
   input logic             capture_dr,
   input logic             shift_dr,
   input logic             update_dr,
   input logic             tdo_oe,
   input logic             cfg_load,
   input logic [CRC_W-1:0] cfg_crc,
   input logic             pass_done,
   input logic [CRC_W-1:0] calc_crc,
   input logic [CRC_W-1:0] ref_crc,
   input logic             crc_err,
   input logic [CRC_W-1:0] shadow
);
   logic picked;
   always_comb picked = user_mode && (ir_value == SEL_CODE);

   // R1
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> ref_crc == $past(cfg_crc));

   // R2
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tdo_oe |-> (picked && shift_dr));

   // R3
   capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (picked && capture_dr) |=> shadow == $past(ref_crc));

   // R4
   update_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (picked && update_dr && !capture_dr && !shift_dr && !cfg_load)
      |=> ref_crc == $past(shadow));

   // R5 R6
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load && !(picked && update_dr)) |=> $stable(ref_crc));

   // R7
   err_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> crc_err == ($past(calc_crc) != $past(ref_crc)));

   // R7
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_done |=> $stable(crc_err));
endmodule

bind refcrc_scan_reg refcrc_scan_chk #(
   .CRC_W(CRC_W), .IR_W(IR_W), .SEL_CODE(SEL_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .ir_value(ir_value),
   .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
   .tdo_oe(tdo_oe), .cfg_load(cfg_load), .cfg_crc(cfg_crc),
   .pass_done(pass_done), .calc_crc(calc_crc), .ref_crc(ref_crc),
   .crc_err(crc_err), .shadow(shadow_q)
);

// File: tb/sim_refcrc_scan_reg.sv
`timescale 1ns/1ps
module sim_refcrc_scan_reg;
   localparam logic [9:0]  SEL  = 10'h015;
   localparam logic [31:0] GOOD = 32'hC704_DD7B;
   localparam logic [31:0] BAD  = 32'h1234_5678;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        user_mode = 1'b0;
   logic [9:0]  ir_value = '0;
   logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
   logic        tdo, tdo_oe;
   logic        cfg_load = 1'b0;
   logic [31:0] cfg_crc = '0;
   logic        pass_done = 1'b0;
   logic [31:0] calc_crc = '0;
   logic [31:0] ref_crc;
   logic        crc_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit exp_q[$];

   always #10 clk = ~clk;

   refcrc_scan_reg u0 (
      .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .ir_value(ir_value),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe), .cfg_load(cfg_load),
      .cfg_crc(cfg_crc), .pass_done(pass_done), .calc_crc(calc_crc),
      .ref_crc(ref_crc), .crc_err(crc_err)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: every driven tdo bit is matched against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && !done && tdo_oe) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R2/R5/R6 unexpected tdo_oe actual=1 expected=0");
         end else begin
            bit e;
            e = exp_q.pop_front();
            if (tdo !== e) begin
               failures++;
               $display("FAIL R3 tdo bit actual=%b expected=%b", tdo, e);
            end
         end
      end
   end

   task automatic scan(input logic [31:0] din, input bit expect_out, input logic [31:0] old);
      capture_dr = 1'b1; tick(); capture_dr = 1'b0;
      for (int i = 0; i < 32; i++) begin
         shift_dr = 1'b1; tdi = din[i];
         if (expect_out) exp_q.push_back(old[i]);
         tick();
      end
      shift_dr = 1'b0; tdi = 1'b0;
      update_dr = 1'b1; tick(); update_dr = 1'b0;
   endtask

   task automatic pass(input logic [31:0] v);
      calc_crc = v; pass_done = 1'b1; tick(); pass_done = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      tick(); tick();
      @(negedge clk);
      check("R8 ref after reset", ref_crc, 32'h0);
      check("R8 err after reset", {31'b0, crc_err}, 32'h0);
      check("R8 tdo_oe after reset", {30'b0, tdo_oe, tdo}, 32'h0);
      rst_n = 1'b1;
      tick();

      // R1 parallel load at end of configuration
      cfg_crc = GOOD; cfg_load = 1'b1; tick(); cfg_load = 1'b0;
      @(negedge clk);
      check("R1 ref after load", ref_crc, GOOD);

      pass(GOOD);
      @(negedge clk);
      check("R7 clean pass", {31'b0, crc_err}, 32'h0);

      // R5 scan outside user mode with the right code
      ir_value = SEL;
      scan(BAD, 1'b0, '0);
      @(negedge clk);
      check("R5 ref unchanged outside user mode", ref_crc, GOOD);

      // R6 wrong instruction codes in user mode
      user_mode = 1'b1;
      ir_value = 10'h016;
      scan(BAD, 1'b0, '0);
      @(negedge clk);
      check("R6 ref unchanged, code 0x016", ref_crc, GOOD);
      check("R6 tdo reads 0", {31'b0, tdo}, 32'h0);
      ir_value = 10'h215;
      scan(BAD, 1'b0, '0);
      @(negedge clk);
      check("R6 ref unchanged, code 0x215", ref_crc, GOOD);

      // R3 R4 inject bad value, saving the good one
      ir_value = SEL;
      scan(BAD, 1'b1, GOOD);
      @(negedge clk);
      check("R4 ref holds injected value", ref_crc, BAD);
      check("R3 all old bits shifted out", exp_q.size(), 32'h0);
      check("R7 err holds until pass", {31'b0, crc_err}, 32'h0);

      pass(GOOD);
      @(negedge clk);
      check("R7 err set after pass", {31'b0, crc_err}, 32'h1);

      // restore the saved value; bad value comes out
      scan(GOOD, 1'b1, BAD);
      @(negedge clk);
      check("R4 ref restored", ref_crc, GOOD);
      check("R7 err holds across rewrite", {31'b0, crc_err}, 32'h1);
      pass(GOOD);
      @(negedge clk);
      check("R7 err cleared after pass", {31'b0, crc_err}, 32'h0);

      // R1 load wins over update in the same cycle
      capture_dr = 1'b1; tick(); capture_dr = 1'b0;
      for (int i = 0; i < 32; i++) begin
         shift_dr = 1'b1; tdi = BAD[i]; exp_q.push_back(GOOD[i]); tick();
      end
      shift_dr = 1'b0;
      update_dr = 1'b1; cfg_load = 1'b1; cfg_crc = 32'hA5A5_0F0F; tick();
      update_dr = 1'b0; cfg_load = 1'b0;
      @(negedge clk);
      check("R1 load priority over update", ref_crc, 32'hA5A5_0F0F);

      // R2 idle selected cycles keep tdo_oe low
      check("R2 tdo_oe idle", {31'b0, tdo_oe}, 32'h0);
      pass(32'hA5A5_0F0E);
      @(negedge clk);
      check("R7 one-bit mismatch flags", {31'b0, crc_err}, 32'h1);

      tick();
      finish_run();
   end
endmodule